// File: doc/BRIEF.md
# Isolated Full-Bridge Gate Pattern Generator with Soft Start and Per-Half Balance

This block drives the four switches of a voltage-fed isolated full bridge. The switches are used as two diagonal pairs. Pair A is `sw1` with `sw4` and conducts in the first half of every switching period. Pair B is `sw2` with `sw3` and conducts in the second half. The current through the transformer primary therefore reverses each half period.

The period is `2*HALF_CNT` clocks. The defaults are 1500 clocks at 60 MHz, which gives 40 kHz per device and 80 kHz at the rectified output. Each pair's on-time is derived from a shared base duty plus a signed trim for that half. The trim lets a current-balance loop outside the block lengthen one half and shorten the other to cancel volt-second imbalance in the core.

After reset, the base duty starts small and grows once per period until the digital bus-at-target flag is seen at a period boundary. From then on the base duty is frozen. An active-low overcurrent input blanks all four gates at once and trips a latch. Only a clear request can release the latch, and the clear starts the soft-start ramp over.

Top module: `fbridge_pwm_ctrl`

## Requirements
- R1: While `rst_n` is low, all four outputs are low. During the first full period after reset release (1500 clocks by default), all four outputs stay low.
- R2: `sw1` always equals `sw4` and `sw2` always equals `sw3`. Pair A and pair B are never high in the same cycle. Pair A goes high at the start of the period and pair B goes high at the start of the second half.
- R3: A period lasts exactly `2*HALF_CNT` clock cycles, so consecutive pair A rising edges are that many cycles apart.
- R4: At each period boundary, each pair's high time for the coming period is set to base + trim. The trim is a two's complement value of `TRIM_W` bits, one per half. The result is clamped to the range 0 to `HALF_CNT - dead_cnt`, and it is 0 when `dead_cnt >= HALF_CNT`.
- R5: The first period whose high time is loaded uses a base of `MIN_DUTY`. At every boundary where `bus_ok` is low, the base grows by `RAMP_STEP`, saturating at `HALF_CNT`.
- R6: Once `bus_ok` is high at a boundary, the base keeps its value at later boundaries even if `bus_ok` falls again. Only a reset or a fault clear releases it.
- R7: A change of trim, dead time or `bus_ok` in the middle of a period leaves that period's pulses unchanged.
- R8: `fault_n` low forces all four outputs low in the same cycle, with no clock edge needed.
- R9: A low `fault_n` seen at a clock edge trips a latch. While the latch is set, all outputs stay low even after `fault_n` returns high.
- R10: `fault_clr` releases the latch only while `fault_n` is high. After a release, one full dark period follows and the ramp starts again from `MIN_DUTY`.
- R11: `fault_clr` asserted while no fault is latched has no effect on the pulses.
- R12: The number of cycles between the fall of pair A and the rise of pair B in the same period is at least the dead time loaded for that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (60 MHz in the reference operating point) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ok | input | 1 | Bus-at-target comparison result, sampled at period boundaries |
| dead_cnt | input | CNT_W | Minimum idle clocks at the end of each half |
| trim_a | input | TRIM_W | Signed on-time correction for pair A (first half) |
| trim_b | input | TRIM_W | Signed on-time correction for pair B (second half) |
| fault_n | input | 1 | Active-low overcurrent indication |
| fault_clr | input | 1 | Request to release a latched fault |
| sw1 | output | 1 | Gate, pair A |
| sw2 | output | 1 | Gate, pair B |
| sw3 | output | 1 | Gate, pair B |
| sw4 | output | 1 | Gate, pair A |

## Verification
The assertions assume that `fault_n`, `fault_clr` and `bus_ok` are already synchronous to `clk`. They also assume that `dead_cnt` stays within `CNT_W` bits, so the saturating gap counter always reaches it. The stimulus keeps to these assumptions by changing every input on a falling clock edge. Trim, dead time and bus flag are altered only at mid-period, so each period's loaded values are known one half period before the boundary. The random trims stay mostly within a modest band around zero, and a few directed windows push them to the most positive and most negative codes and raise the dead time past the half period.

// File: rtl/fbp_pkg.sv
package fbp_pkg;

   // Gate pattern of the two diagonal pairs, a = first half, b = second half
   typedef struct packed {
      logic a;
      logic b;
   } pair_t;

   // Number of legs with an individually trimmed on-time
   localparam int NUM_LEGS = 2;

endpackage

// File: rtl/fbp_period_timer.sv
module fbp_period_timer #(
   parameter int HALF_CNT = 750,
   parameter int CNT_W    = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   localparam int               PERIOD = 2 * HALF_CNT;
   localparam logic [CNT_W-1:0] LAST_V = CNT_W'(PERIOD - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!run) begin
         cnt <= '0;
      end else if (cnt == LAST_V) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   assign wrap = run && (cnt == LAST_V);

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST_V); // R3
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0)); // R3

endmodule

// File: rtl/fbp_softstart.sv
module fbp_softstart #(
   parameter int HALF_CNT  = 750,
   parameter int CNT_W     = 11,
   parameter int MIN_DUTY  = 15,
   parameter int RAMP_STEP = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             wrap,
   input  logic             bus_ok,
   output logic [CNT_W-1:0] base
);

   localparam logic [CNT_W-1:0] MIN_V  = CNT_W'(MIN_DUTY);
   localparam logic [CNT_W-1:0] CAP_V  = CNT_W'(HALF_CNT);
   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(RAMP_STEP);
   localparam logic [CNT_W-1:0] TOP_V  = CNT_W'(HALF_CNT - RAMP_STEP);

   logic reached;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base    <= MIN_V;
         reached <= 1'b0;
      end else if (restart) begin
         base    <= MIN_V;
         reached <= 1'b0;
      end else if (wrap) begin
         if (bus_ok) begin
            reached <= 1'b1;
         end else if (!reached) begin
            base <= (base >= TOP_V) ? CAP_V : base + STEP_V;
         end
      end
   end

   AST_BASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (reached && !restart) |=> $stable(base)); // R6
   AST_BASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!wrap && !restart) |=> $stable(base)); // R5
   AST_BASE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      base <= CAP_V); // R5

endmodule

// File: rtl/fbp_leg_width.sv
module fbp_leg_width #(
   parameter int HALF_CNT = 750,
   parameter int CNT_W    = 11,
   parameter int TRIM_W   = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clear,
   input  logic                     load,
   input  logic [CNT_W-1:0]         base,
   input  logic signed [TRIM_W-1:0] trim,
   input  logic [CNT_W-1:0]         dead,
   output logic [CNT_W-1:0]         width
);

   localparam int               SW     = CNT_W + 2;
   localparam logic [CNT_W-1:0] HALF_V = CNT_W'(HALF_CNT);

   logic signed [SW-1:0] req;
   logic signed [SW-1:0] lim_s;
   logic [CNT_W-1:0]     lim;
   logic [CNT_W-1:0]     fitted;

   // Longest allowed on-time keeps at least the dead time idle per half
   assign lim   = (dead >= HALF_V) ? '0 : HALF_V - dead;
   assign lim_s = $signed({2'b00, lim});
   assign req   = $signed({2'b00, base}) + SW'(trim);

   always_comb begin
      if (req[SW-1]) begin
         fitted = '0;
      end else if (req > lim_s) begin
         fitted = lim;
      end else begin
         fitted = req[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width <= '0;
      end else if (clear) begin
         width <= '0;
      end else if (load) begin
         width <= fitted;
      end
   end

   AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !clear) |=> $stable(width)); // R7
   AST_DARK_TRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (width == '0)); // R10

endmodule

// File: rtl/fbp_gate_drive.sv
module fbp_gate_drive
   import fbp_pkg::*;
#(
   parameter int HALF_CNT = 750,
   parameter int CNT_W    = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] width_a,
   input  logic [CNT_W-1:0] width_b,
   output pair_t            gq
);

   localparam logic [CNT_W-1:0] HALF_V = CNT_W'(HALF_CNT);

   logic             in_b;
   logic [CNT_W-1:0] off_b;
   logic             want_a;
   logic             want_b;

   assign in_b   = (cnt >= HALF_V);
   assign off_b  = cnt - HALF_V;
   assign want_a = !in_b && (cnt < width_a);
   assign want_b = in_b && (off_b < width_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gq <= '0;
      end else begin
         gq.a <= enable & want_a;
         gq.b <= enable & want_b;
      end
   end

   AST_OFF_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (gq == '0)); // R9

endmodule

// File: rtl/fbp_fault_latch.sv
module fbp_fault_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic fault_n,
   input  logic fault_clr,
   output logic tripped
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tripped <= 1'b0;
      end else if (!fault_n) begin
         tripped <= 1'b1;
      end else if (fault_clr) begin
         tripped <= 1'b0;
      end
   end

   AST_TRIP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n |=> tripped); // R9
   AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tripped && !fault_clr) |=> tripped); // R9
   AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (tripped && !fault_n) |=> tripped); // R10

endmodule

// File: rtl/fbridge_pwm_ctrl.sv
module fbridge_pwm_ctrl
   import fbp_pkg::*;
#(
   parameter int HALF_CNT  = 750,
   parameter int CNT_W     = 11,
   parameter int TRIM_W    = 10,
   parameter int MIN_DUTY  = 15,
   parameter int RAMP_STEP = 30
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_ok,
   input  logic [CNT_W-1:0]         dead_cnt,
   input  logic signed [TRIM_W-1:0] trim_a,
   input  logic signed [TRIM_W-1:0] trim_b,
   input  logic                     fault_n,
   input  logic                     fault_clr,
   output logic                     sw1,
   output logic                     sw2,
   output logic                     sw3,
   output logic                     sw4
);

   // Elaboration-time parameter checks
   if (HALF_CNT < 2) begin : g_chk_half
      $error("HALF_CNT must be at least 2");
   end
   if (CNT_W < $clog2(2 * HALF_CNT)) begin : g_chk_cnt
      $error("CNT_W too narrow for the period");
   end
   if (TRIM_W > CNT_W + 1) begin : g_chk_trim
      $error("TRIM_W must not exceed CNT_W+1");
   end
   if (MIN_DUTY < 0 || MIN_DUTY > HALF_CNT) begin : g_chk_min
      $error("MIN_DUTY out of range");
   end
   if (RAMP_STEP < 1 || RAMP_STEP > HALF_CNT) begin : g_chk_step
      $error("RAMP_STEP out of range");
   end

   logic                     tripped;
   logic                     wrap;
   logic [CNT_W-1:0]         cnt;
   logic [CNT_W-1:0]         base;
   logic [CNT_W-1:0]         width [NUM_LEGS];
   logic signed [TRIM_W-1:0] trim_v [NUM_LEGS];
   logic                     gate_en;
   pair_t                    gq;

   assign trim_v[0] = trim_a;
   assign trim_v[1] = trim_b;
   assign gate_en   = ~tripped & fault_n;

   fbp_fault_latch i_fault (
      .clk       (clk),
      .rst_n     (rst_n),
      .fault_n   (fault_n),
      .fault_clr (fault_clr),
      .tripped   (tripped)
   );

   fbp_period_timer #(
      .HALF_CNT (HALF_CNT),
      .CNT_W    (CNT_W)
   ) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (~tripped),
      .cnt   (cnt),
      .wrap  (wrap)
   );

   fbp_softstart #(
      .HALF_CNT  (HALF_CNT),
      .CNT_W     (CNT_W),
      .MIN_DUTY  (MIN_DUTY),
      .RAMP_STEP (RAMP_STEP)
   ) i_ramp (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (tripped),
      .wrap    (wrap),
      .bus_ok  (bus_ok),
      .base    (base)
   );

   for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
      fbp_leg_width #(
         .HALF_CNT (HALF_CNT),
         .CNT_W    (CNT_W),
         .TRIM_W   (TRIM_W)
      ) i_width (
         .clk   (clk),
         .rst_n (rst_n),
         .clear (tripped),
         .load  (wrap),
         .base  (base),
         .trim  (trim_v[g]),
         .dead  (dead_cnt),
         .width (width[g])
      );
   end

   fbp_gate_drive #(
      .HALF_CNT (HALF_CNT),
      .CNT_W    (CNT_W)
   ) i_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (gate_en),
      .cnt     (cnt),
      .width_a (width[0]),
      .width_b (width[1]),
      .gq      (gq)
   );

   // Immediate blanking by the fault pin, then by the latch
   assign sw1 = gq.a & gate_en;
   assign sw4 = gq.a & gate_en;
   assign sw2 = gq.b & gate_en;
   assign sw3 = gq.b & gate_en;

   // Support state for the idle-gap check
   logic [CNT_W-1:0] dead_lat;
   logic [CNT_W-1:0] gap_q;
   logic             b_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dead_lat <= '0;
         gap_q    <= '1;
         b_prev   <= 1'b0;
      end else begin
         if (wrap) dead_lat <= dead_cnt;
         b_prev <= gq.b;
         if (gq.a || gq.b) begin
            gap_q <= '0;
         end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !((sw1 || sw4) && (sw2 || sw3))); // R2
   AST_KILL_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      !fault_n |=> !(sw1 || sw2 || sw3 || sw4)); // R9
   AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (gq.b && !b_prev) |-> (gap_q >= dead_lat)); // R12

endmodule

// File: tb/test_fbridge_pwm_ctrl.sv
`timescale 1ns/1ps
module test_fbridge_pwm_ctrl;

   localparam int HALF  = 750;
   localparam int PER   = 2 * HALF;
   localparam int MIN_D = 15;
   localparam int STEP  = 30;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              bus_ok;
   logic [10:0]       dead_cnt;
   logic signed [9:0] trim_a;
   logic signed [9:0] trim_b;
   logic              fault_n;
   logic              fault_clr;
   logic              sw1, sw2, sw3, sw4;

   always #2.5 clk = ~clk;

   fbridge_pwm_ctrl i_fbridge_pwm_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_ok    (bus_ok),
      .dead_cnt  (dead_cnt),
      .trim_a    (trim_a),
      .trim_b    (trim_b),
      .fault_n   (fault_n),
      .fault_clr (fault_clr),
      .sw1       (sw1),
      .sw2       (sw2),
      .sw3       (sw3),
      .sw4       (sw4)
   );

   int nchk = 0;
   int nbad = 0;
   int cyc  = 0;
   bit finished = 1'b0;

   // Reference model state
   int m_base;
   bit m_reached;
   int exp_a;
   int exp_b;
   int win_idx;
   int rise_win;
   int rise_cyc;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   function automatic int fit(input int req, input int dead);
      int lim;
      lim = (dead >= HALF) ? 0 : HALF - dead;
      if (req < 0) return 0;
      if (req > lim) return lim;
      return req;
   endfunction

   task automatic set_inputs(input bit b, input int ta, input int tb, input int d);
      bus_ok   = b;
      trim_a   = 10'(ta);
      trim_b   = 10'(tb);
      dead_cnt = 11'(d);
   endtask

   task automatic restart_model();
      m_base    = MIN_D;
      m_reached = 1'b0;
      exp_a     = 0;
      exp_b     = 0;
      win_idx   = 0;
      rise_win  = -10;
      rise_cyc  = 0;
   endtask

   // One switching period; new inputs are applied at its midpoint
   task automatic run_window(input string tag, input bit nb, input int nta,
                             input int ntb, input int nd, input bit poke);
      int ca = 0;
      int cb = 0;
      int pairing = 0;
      int overlap = 0;
      bit pa = 1'b0;
      for (int i = 1; i <= PER; i++) begin
         @(posedge clk);
         @(negedge clk);
         if (sw1 != sw4 || sw2 != sw3) pairing++;
         if ((sw1 || sw4) && (sw2 || sw3)) overlap++;
         if (sw1) ca++;
         if (sw2) cb++;
         if (sw1 && !pa) begin
            if (rise_win == win_idx - 1)
               check(cyc - rise_cyc == PER, "R3 period length", cyc - rise_cyc, PER);
            rise_win = win_idx;
            rise_cyc = cyc;
         end
         pa = sw1;
         if (i == HALF) begin
            set_inputs(nb, nta, ntb, nd);
            if (poke) fault_clr = 1'b1;
         end
         if (i == HALF + 1) fault_clr = 1'b0;
      end
      check(ca == exp_a, {tag, " pair A width"}, ca, exp_a);
      check(cb == exp_b, {tag, " pair B width, R7 mid-period change"}, cb, exp_b);
      check(pairing == 0 && overlap == 0, "R2 pairing and exclusion", pairing + overlap, 0);
      exp_a = fit(m_base + nta, nd);
      exp_b = fit(m_base + ntb, nd);
      if (nb) m_reached = 1'b1;
      else if (!m_reached) m_base = (m_base + STEP > HALF) ? HALF : m_base + STEP;
      win_idx++;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         nbad++;
         nchk++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", nchk, nbad);
         $finish;
      end
   end

   initial begin
      int unsigned seed_v;
      int zero_bad;
      seed_v = $urandom(32'd2024);
      rst_n     = 1'b0;
      fault_n   = 1'b1;
      fault_clr = 1'b0;
      set_inputs(1'b0, 0, 0, 60);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check({sw1, sw2, sw3, sw4} == 4'b0, "R1 outputs low in reset", int'({sw1, sw2, sw3, sw4}), 0);
      rst_n = 1'b1;
      restart_model();

      run_window("R1 first period dark", 1'b0, 0, 0, 60, 1'b0);
      for (int k = 0; k < 7; k++) run_window("R5 ramp", 1'b0, 0, 0, 60, 1'b0);
      run_window("R5 ramp then bus at target", 1'b1, 0, 0, 60, 1'b0);

      // Regulated hold with random trims, dead times and bus flag
      for (int k = 0; k < 10; k++) begin
         run_window("R6 R4 regulated hold", 1'b0 ^ bit'($urandom_range(1)),
                    int'($urandom_range(240)) - 120, int'($urandom_range(240)) - 120,
                    20 + int'($urandom_range(180)), 1'b0);
      end
      run_window("R4 extreme trims", 1'b0, 511, -512, 60, 1'b0);
      run_window("R4 clamp to limit and zero", 1'b0, 0, 0, 800, 1'b0);
      run_window("R4 dead beyond half", 1'b0, 0, 0, 60, 1'b0);
      run_window("R11 stray clear", 1'b0, 0, 0, 60, 1'b1);
      run_window("R11 after stray clear", 1'b0, 0, 0, 60, 1'b0);

      // Fault sequence, pair A is driving at this point
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      check(sw1 == 1'b1, "R2 pair A leads the period", int'(sw1), 1);
      fault_n = 1'b0;
      #0.5;
      check({sw1, sw2, sw3, sw4} == 4'b0, "R8 immediate blanking", int'({sw1, sw2, sw3, sw4}), 0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      fault_clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      fault_clr = 1'b0;
      fault_n   = 1'b1;
      zero_bad = 0;
      for (int k = 0; k < 40; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (sw1 || sw2 || sw3 || sw4) zero_bad++;
      end
      check(zero_bad == 0, "R9 R10 latched off, clear during fault ignored", zero_bad, 0);
      fault_clr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      fault_clr = 1'b0;
      restart_model();

      run_window("R10 dark period after clear", 1'b0, 0, 0, 10, 1'b0);
      for (int k = 0; k < 28; k++) run_window("R10 R5 ramp restart and saturation", 1'b0, 0, 0, 10, 1'b0);
      check(m_base == HALF, "R5 base saturated in model", m_base, HALF);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

endmodule